// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block buffers one direction of traffic between two unrelated clock domains. A writer pushes 36-bit words into a 256-entry store on its own clock, and a reader pulls them out in arrival order on a second clock. Each port samples an enable, a request and a direction bit on its rising edge. It answers with an acknowledge one cycle later, but only when the access actually took place. A writer that races the full boundary, or a reader that races the empty boundary, can therefore tell whether its word went through.

Five level flags describe occupancy: full, almost-full and half-full in the write domain, and almost-empty and empty in the read domain. The two almost-flag distances can be programmed from their own domains and come out of reset at eight words. The reader can place a marker on its current position (reset also places it at zero). A rewind strobe returns the read position to that marker, so a stored block of up to 256 words can be read as many times as needed.

Top module: `dcfifo_flags`

## Requirements
- R1: After reset the empty and almost-empty flags are 1, full, almost-full and half-full are 0, both acknowledges are 0, and both almost-distances are 8.
- R2: On a rising write-clock edge with wr_en_i=1, wr_req_i=1, wr_dir_i=1 (1 means write) and full_o=0, the word on wr_data_i is stored.
- R3: On a rising read-clock edge with rd_en_i=1, rd_req_i=1, rd_dir_i=0 (0 means read), empty_o=0 and rt_i=0, the oldest stored word is removed and appears on rd_data_o after that edge. Words leave in the order they were written.
- R4: An acknowledge goes high for the one cycle after an accepted access. A write attempted while full, or a read attempted while empty, is dropped: its acknowledge stays 0, the stored words are unchanged, and rd_data_o keeps its value.
- R5: full_o is 1 exactly when 256 words are held, and empty_o is 1 exactly when none are held.
- R6: afull_o is 1 when occupancy is at least 256 minus the almost-full distance. aempty_o is 1 when occupancy is at most the almost-empty distance.
- R7: half_o is 1 when occupancy is at least 128 words.
- R8: A pulse on af_set_i (write clock) loads af_val_i, and a pulse on ae_set_i (read clock) loads ae_val_i, as the new distance. Any value from 0 to 256 is accepted, and larger values are clamped to 256.
- R9: rt_i moves the read position back to the marker, and empty and almost-empty follow the restored position at once. The marker is set to zero by reset and to the current read position by mark_i.
- R10: An access with the enable low, the request low or the wrong direction bit does nothing and is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk_i | input | 1 | Write-domain clock |
| rclk_i | input | 1 | Read-domain clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| wr_en_i | input | 1 | Write port enable |
| wr_req_i | input | 1 | Write request |
| wr_dir_i | input | 1 | Direction bit, 1 selects write |
| wr_data_i | input | 36 | Word to store |
| wr_ack_o | output | 1 | Write accepted on the previous edge |
| af_set_i | input | 1 | Load almost-full distance |
| af_val_i | input | 9 | New almost-full distance |
| full_o | output | 1 | 256 words held |
| afull_o | output | 1 | Almost-full |
| half_o | output | 1 | At least 128 words held |
| rd_en_i | input | 1 | Read port enable |
| rd_req_i | input | 1 | Read request |
| rd_dir_i | input | 1 | Direction bit, 0 selects read |
| rd_data_o | output | 36 | Word removed on the last accepted read |
| rd_ack_o | output | 1 | Read accepted on the previous edge |
| ae_set_i | input | 1 | Load almost-empty distance |
| ae_val_i | input | 9 | New almost-empty distance |
| rt_i | input | 1 | Rewind read position to the marker |
| mark_i | input | 1 | Place the marker at the read position |
| empty_o | output | 1 | No words held |
| aempty_o | output | 1 | Almost-empty |

## Verification
On every edge, the bound checker confirms four things. A write against full and a read against empty are never acknowledged, and an acknowledge always traces back to a matching request. A rewind cycle never acknowledges a read. Full always implies almost-full and half-full, and empty always implies almost-empty. Exact flag thresholds, the data order, the clamping of programmed distances and the replayed content after a rewind depend on stored values and occupancy history. Only the bench's scenarios show these, by walking occupancy across each boundary and reading the words back.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
  typedef enum logic {DIR_RD = 1'b0, DIR_WR = 1'b1} dir_e;
  localparam int DEF_DEPTH = 256;
  localparam int DEF_WIDTH = 36;
  localparam int DEF_OFF   = 8;
endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
module dcf_sync #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      q_o  <= '0;
    end else begin
      s1_q <= d_i;
      q_o  <= s1_q;
    end
  end
endmodule

// File: rtl/dcf_ram.sv
`timescale 1ns/1ps
module dcf_ram #(
  parameter  int DEPTH = 256,
  parameter  int WIDTH = 36,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             wclk_i,
  input  logic             rclk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             re_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/dcf_wr_side.sv
`timescale 1ns/1ps
module dcf_wr_side #(
  parameter  int DEPTH   = 256,
  parameter  int OFF_DEF = 8,
  localparam int AW      = $clog2(DEPTH),
  localparam int PTR_W   = AW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             req_i,
  input  logic             dir_i,
  input  logic             set_i,
  input  logic [PTR_W-1:0] val_i,
  input  logic [PTR_W-1:0] rgray_i,
  output logic             we_o,
  output logic [AW-1:0]    waddr_o,
  output logic [PTR_W-1:0] wgray_o,
  output logic             ack_o,
  output logic             full_o,
  output logic             afull_o,
  output logic             half_o
);
  localparam logic [PTR_W-1:0] DEPTH_L = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] HALF_L  = PTR_W'(DEPTH / 2);
  localparam logic [PTR_W-1:0] DEF_L   = PTR_W'(OFF_DEF);

  logic [PTR_W-1:0] wbin_q, wnext, rbin, occ, off_q;

  always_comb begin
    for (int i = 0; i < PTR_W; i++) rbin[i] = ^(rgray_i >> i);
  end

  assign wnext   = wbin_q + 1'b1;
  assign occ     = wbin_q - rbin;
  assign full_o  = (occ == DEPTH_L);
  assign afull_o = (occ >= DEPTH_L - off_q);
  assign half_o  = (occ >= HALF_L);
  assign we_o    = en_i && req_i && (dir_i == dcf_pkg::DIR_WR) && !full_o;
  assign waddr_o = wbin_q[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_o <= '0;
      ack_o   <= 1'b0;
      off_q   <= DEF_L;
    end else begin
      ack_o <= we_o;
      if (we_o) begin
        wbin_q  <= wnext;
        wgray_o <= wnext ^ (wnext >> 1);
      end
      if (set_i) off_q <= (val_i > DEPTH_L) ? DEPTH_L : val_i;
    end
  end
endmodule

// File: rtl/dcf_rd_side.sv
`timescale 1ns/1ps
module dcf_rd_side #(
  parameter  int DEPTH   = 256,
  parameter  int OFF_DEF = 8,
  localparam int AW      = $clog2(DEPTH),
  localparam int PTR_W   = AW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             req_i,
  input  logic             dir_i,
  input  logic             set_i,
  input  logic [PTR_W-1:0] val_i,
  input  logic             rt_i,
  input  logic             mark_i,
  input  logic [PTR_W-1:0] wgray_i,
  output logic             re_o,
  output logic [AW-1:0]    raddr_o,
  output logic [PTR_W-1:0] rgray_o,
  output logic             ack_o,
  output logic             empty_o,
  output logic             aempty_o
);
  localparam logic [PTR_W-1:0] DEPTH_L = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] DEF_L   = PTR_W'(OFF_DEF);

  logic [PTR_W-1:0] rbin_q, rbin_d, mark_q, wbin, occ, off_q;

  always_comb begin
    for (int i = 0; i < PTR_W; i++) wbin[i] = ^(wgray_i >> i);
  end

  assign occ      = wbin - rbin_q;
  assign empty_o  = (occ == '0);
  assign aempty_o = (occ <= off_q);
  assign re_o     = en_i && req_i && (dir_i == dcf_pkg::DIR_RD) && !empty_o && !rt_i;
  assign raddr_o  = rbin_q[AW-1:0];

  // rewind wins over a read in the same cycle
  always_comb begin
    rbin_d = rbin_q;
    if (rt_i)      rbin_d = mark_q;
    else if (re_o) rbin_d = rbin_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_o <= '0;
      mark_q  <= '0;
      ack_o   <= 1'b0;
      off_q   <= DEF_L;
    end else begin
      ack_o   <= re_o;
      rbin_q  <= rbin_d;
      rgray_o <= rbin_d ^ (rbin_d >> 1);
      if (mark_i && !rt_i) mark_q <= rbin_q;
      if (set_i) off_q <= (val_i > DEPTH_L) ? DEPTH_L : val_i;
    end
  end
endmodule

// File: rtl/dcfifo_flags.sv
`timescale 1ns/1ps
module dcfifo_flags #(
  parameter  int WIDTH   = dcf_pkg::DEF_WIDTH,
  parameter  int DEPTH   = dcf_pkg::DEF_DEPTH,
  parameter  int OFF_DEF = dcf_pkg::DEF_OFF,
  localparam int AW      = $clog2(DEPTH),
  localparam int PTR_W   = AW + 1
) (
  input  logic             wclk_i,
  input  logic             rclk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_req_i,
  input  logic             wr_dir_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic             wr_ack_o,
  input  logic             af_set_i,
  input  logic [PTR_W-1:0] af_val_i,
  output logic             full_o,
  output logic             afull_o,
  output logic             half_o,
  input  logic             rd_en_i,
  input  logic             rd_req_i,
  input  logic             rd_dir_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             rd_ack_o,
  input  logic             ae_set_i,
  input  logic [PTR_W-1:0] ae_val_i,
  input  logic             rt_i,
  input  logic             mark_i,
  output logic             empty_o,
  output logic             aempty_o
);
  logic             we, re;
  logic [AW-1:0]    waddr, raddr;
  logic [PTR_W-1:0] wgray, rgray, wgray_rs, rgray_ws;

  dcf_wr_side #(.DEPTH(DEPTH), .OFF_DEF(OFF_DEF)) u_wr (
    .clk_i(wclk_i), .rst_ni(rst_ni),
    .en_i(wr_en_i), .req_i(wr_req_i), .dir_i(wr_dir_i),
    .set_i(af_set_i), .val_i(af_val_i), .rgray_i(rgray_ws),
    .we_o(we), .waddr_o(waddr), .wgray_o(wgray), .ack_o(wr_ack_o),
    .full_o(full_o), .afull_o(afull_o), .half_o(half_o)
  );

  dcf_rd_side #(.DEPTH(DEPTH), .OFF_DEF(OFF_DEF)) u_rd (
    .clk_i(rclk_i), .rst_ni(rst_ni),
    .en_i(rd_en_i), .req_i(rd_req_i), .dir_i(rd_dir_i),
    .set_i(ae_set_i), .val_i(ae_val_i), .rt_i(rt_i), .mark_i(mark_i),
    .wgray_i(wgray_rs), .re_o(re), .raddr_o(raddr), .rgray_o(rgray),
    .ack_o(rd_ack_o), .empty_o(empty_o), .aempty_o(aempty_o)
  );

  dcf_sync #(.W(PTR_W)) u_w2r (.clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wgray), .q_o(wgray_rs));
  dcf_sync #(.W(PTR_W)) u_r2w (.clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rgray), .q_o(rgray_ws));

  dcf_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ram (
    .wclk_i(wclk_i), .rclk_i(rclk_i), .rst_ni(rst_ni),
    .we_i(we), .waddr_i(waddr), .wdata_i(wr_data_i),
    .re_i(re), .raddr_i(raddr), .rdata_o(rd_data_o)
  );
endmodule

// File: rtl/dcfifo_flags_chk.sv
`timescale 1ns/1ps
module dcfifo_flags_chk (
  input logic rst_ni,
  input logic wclk_i,
  input logic rclk_i,
  input logic wr_en_i,
  input logic wr_req_i,
  input logic wr_dir_i,
  input logic wr_ack_o,
  input logic full_o,
  input logic afull_o,
  input logic half_o,
  input logic rd_en_i,
  input logic rd_req_i,
  input logic rd_dir_i,
  input logic rd_ack_o,
  input logic rt_i,
  input logic empty_o,
  input logic aempty_o
);
  p_no_overflow_r4: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (full_o && wr_en_i && wr_req_i && wr_dir_i) |=> !wr_ack_o);

  p_no_underflow_r4: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (empty_o && rd_en_i && rd_req_i && !rd_dir_i) |=> !rd_ack_o);

  p_wr_ack_src_r2: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    wr_ack_o |-> $past(wr_en_i && wr_req_i && wr_dir_i));

  p_rd_ack_src_r3: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    rd_ack_o |-> $past(rd_en_i && rd_req_i && !rd_dir_i));

  p_full_levels_r7: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full_o |-> (afull_o && half_o));

  p_empty_levels_r6: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    empty_o |-> aempty_o);

  p_rewind_no_ack_r9: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    rt_i |=> !rd_ack_o);
endmodule

bind dcfifo_flags dcfifo_flags_chk u_chk (
  .rst_ni(rst_ni), .wclk_i(wclk_i), .rclk_i(rclk_i),
  .wr_en_i(wr_en_i), .wr_req_i(wr_req_i), .wr_dir_i(wr_dir_i), .wr_ack_o(wr_ack_o),
  .full_o(full_o), .afull_o(afull_o), .half_o(half_o),
  .rd_en_i(rd_en_i), .rd_req_i(rd_req_i), .rd_dir_i(rd_dir_i), .rd_ack_o(rd_ack_o),
  .rt_i(rt_i), .empty_o(empty_o), .aempty_o(aempty_o)
);

// File: tb/dcfifo_flags_test.sv
`timescale 1ns/1ps
module dcfifo_flags_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 0, wr_req = 0, wr_dir = 0, af_set = 0;
  logic [35:0] wr_data = '0;
  logic [8:0]  af_val = '0, ae_val = '0;
  logic        rd_en = 0, rd_req = 0, rd_dir = 0, ae_set = 0, rt = 0, mark = 0;
  logic        wr_ack, full, afull, half, rd_ack, empty, aempty;
  logic [35:0] rd_data;

  int total = 0, bad = 0;
  bit done = 0;
  logic [35:0] wval = 36'h100, rval = 36'h100;

  always #2 clk = ~clk;

  dcfifo_flags uut (
    .wclk_i(clk), .rclk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_req_i(wr_req), .wr_dir_i(wr_dir), .wr_data_i(wr_data),
    .wr_ack_o(wr_ack), .af_set_i(af_set), .af_val_i(af_val),
    .full_o(full), .afull_o(afull), .half_o(half),
    .rd_en_i(rd_en), .rd_req_i(rd_req), .rd_dir_i(rd_dir), .rd_data_o(rd_data),
    .rd_ack_o(rd_ack), .ae_set_i(ae_set), .ae_val_i(ae_val),
    .rt_i(rt), .mark_i(mark), .empty_o(empty), .aempty_o(aempty)
  );

  // {write, count[8:0], flags {full,afull,half,aempty,empty}}
  localparam logic [14:0] VEC [9] = '{
    {1'b1, 9'd1,   5'b00010},
    {1'b1, 9'd7,   5'b00010},
    {1'b1, 9'd1,   5'b00000},
    {1'b1, 9'd119, 5'b00100},
    {1'b0, 9'd1,   5'b00000},
    {1'b1, 9'd120, 5'b00100},
    {1'b1, 9'd1,   5'b01100},
    {1'b1, 9'd8,   5'b11100},
    {1'b0, 9'd256, 5'b00011}
  };

  function automatic logic [4:0] flags();
    return {full, afull, half, aempty, empty};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    wr_en = 0; wr_req = 0; rd_en = 0; rd_req = 0;
    rt = 0; mark = 0; ae_set = 0; af_set = 0;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr1(input logic en, input logic req, input logic dir,
                     input logic [35:0] d, output logic ack);
    @(negedge clk);
    wr_en = en; wr_req = req; wr_dir = dir; wr_data = d;
    @(posedge clk); #1 ack = wr_ack;
  endtask

  task automatic rd1(input logic en, input logic req, input logic dir,
                     output logic ack, output logic [35:0] d);
    @(negedge clk);
    rd_en = en; rd_req = req; rd_dir = dir;
    @(posedge clk); #1 ack = rd_ack; d = rd_data;
  endtask

  task automatic wr_n(input int n, input string tag);
    int acks = 0;
    logic a;
    for (int i = 0; i < n; i++) begin
      wr1(1, 1, 1, wval, a);
      if (a) begin acks++; wval++; end
    end
    idle();
    chk(tag, acks, n);
  endtask

  task automatic rd_n(input int n, input string tag);
    int errs = 0;
    logic a;
    logic [35:0] d;
    for (int i = 0; i < n; i++) begin
      rd1(1, 1, 0, a, d);
      if (!a || d !== rval) errs++;
      rval++;
    end
    idle();
    chk(tag, errs, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [35:0] d, last;
    logic [35:0] base;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 flags in reset", flags(), 5'b00011);
    rst_n = 1'b1;
    settle();
    chk("R1 flags after reset", flags(), 5'b00011);
    chk("R1 acks after reset", {wr_ack, rd_ack}, 2'b00);

    // table walk: R2 R3 R5 R6 R7 with default distances
    for (int i = 0; i < 9; i++) begin
      logic [14:0] v;
      v = VEC[i];
      if (v[14]) wr_n(int'(v[13:5]), "R2 table write");
      else       rd_n(int'(v[13:5]), "R3 table read order");
      settle();
      chk("R5 R6 R7 table flags", flags(), v[4:0]);
    end

    // R4 write while full is dropped
    wr_n(256, "R2 fill");
    settle();
    chk("R5 full flags", flags(), 5'b11100);
    wr1(1, 1, 1, 36'hBADBAD, a);
    idle();
    chk("R4 write at full not acked", a, 1'b0);
    settle();
    chk("R4 still full", full, 1'b1);
    rd_n(256, "R4 no overwrite on drop");
    settle();
    chk("R5 empty after drain", flags(), 5'b00011);

    // R4 read while empty is dropped
    last = rd_data;
    rd1(1, 1, 0, a, d);
    idle();
    chk("R4 read at empty not acked", a, 1'b0);
    chk("R4 data held on dropped read", rd_data, last);

    // R10 disabled or misdirected access
    wr1(0, 1, 1, wval, a);
    idle();
    chk("R10 write enable low no ack", a, 1'b0);
    wr1(1, 0, 1, wval, a);
    idle();
    chk("R10 write request low no ack", a, 1'b0);
    settle();
    chk("R10 nothing stored", empty, 1'b1);
    wr_n(1, "R2 single write");
    settle();
    rd1(1, 1, 1, a, d);
    idle();
    chk("R10 read wrong dir no ack", a, 1'b0);
    settle();
    chk("R10 word still held", empty, 1'b0);
    rd_n(1, "R3 single read");
    settle();

    // R8 programmed distances
    @(negedge clk);
    ae_val = 9'd3; ae_set = 1; af_val = 9'd2; af_set = 1;
    idle();
    wr_n(3, "R2 write 3");
    settle();
    chk("R8 aempty at 3 with distance 3", aempty, 1'b1);
    wr_n(1, "R2 write 4th");
    settle();
    chk("R8 aempty clear at 4", aempty, 1'b0);
    wr_n(249, "R2 write to 253");
    settle();
    chk("R8 afull clear at 253 with distance 2", afull, 1'b0);
    wr_n(1, "R2 write to 254");
    settle();
    chk("R8 afull set at 254", afull, 1'b1);
    rd_n(254, "R3 drain 254");
    settle();
    @(negedge clk);
    af_val = 9'd400; af_set = 1;
    idle();
    chk("R8 clamp to 256 makes afull while empty", afull, 1'b1);

    // R1 defaults restored by reset
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    settle();
    chk("R1 afull distance back to 8", afull, 1'b0);

    // R9 rewind and marker
    rval = wval;
    base = wval;
    wr_n(5, "R2 block write");
    settle();
    rd_n(5, "R3 block read");
    settle();
    chk("R9 empty before rewind", empty, 1'b1);
    @(negedge clk); rt = 1;
    idle();
    chk("R9 rewind to reset marker", empty, 1'b0);
    rval = base;
    rd_n(5, "R9 replay from reset marker");
    @(negedge clk); rt = 1;
    idle();
    rval = base;
    rd_n(2, "R9 replay first two");
    @(negedge clk); mark = 1;
    idle();
    rd_n(3, "R9 read past mark");
    settle();
    chk("R9 empty before second rewind", empty, 1'b1);
    @(negedge clk); rt = 1;
    idle();
    rval = base + 36'd2;
    rd_n(3, "R9 replay from mark");
    settle();
    chk("R9 empty after replay", empty, 1'b1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule